// File: doc/BRIEF.md
# SPI Flash Host Command Sequencer

This block is the host side of a serial flash link. It runs SPI mode 0 and has one request port. A request gives an operation code, a 24-bit address and a byte count. The block turns each request into the bus transactions it needs: the command byte, any address and dummy bytes, and the data bytes. Write data arrives one byte at a time, and the block pulls each byte just before it shifts that byte out. Read data is returned one byte at a time with a valid strobe. Every field goes out most significant bit first. The serial clock runs at a fixed division of the system clock.

For programs and erases the block first sends a write-enable transaction of its own. It then sends the command. After that it keeps reading the status register until the busy flag is clear. Only then does it report completion. A request that makes no sense is refused with an error strobe and causes no bus traffic: a read or program with no bytes, or an unknown operation code.

Top module: `spi_flash_seq`

## Requirements
- R1: While reset is held and after it is released: cs_n is 1, sck is 0, req_ready is 1, and done, err and rd_valid are 0.
- R2: SPI mode 0 timing applies.
  - sck is 0 whenever cs_n is 1.
  - While cs_n is low, mosi changes only in the cycle in which sck falls.
  - miso is sampled when sck rises.
  - Every byte goes out most significant bit first.
- R3: A request with req_op 0 (read) is one transaction: 03h, then address bits 23:16, 15:8 and 7:0, then req_len bytes. Each of those bytes is returned on rd_data with a one-cycle rd_valid pulse.
- R4: A request with req_op 1 (fast read) is one transaction: 0Bh, then the three address bytes, then one 00h dummy byte, then req_len bytes returned on rd_data. The dummy byte is not returned.
- R5: For req_op 2 to 6 (write-type), the first transaction is the single byte 06h, and cs_n is raised before the command transaction starts.
- R6: Erase mapping:
  - req_op 3 sends 20h plus the three address bytes.
  - req_op 4 sends 52h plus the three address bytes.
  - req_op 5 sends D8h plus the three address bytes.
  - req_op 6 sends the single byte 60h.
- R7: req_op 2 (program) sends 02h, the three address bytes, then req_len bytes. Each data byte is the value on wr_data in the cycle in which wr_ready is 1.
- R8: After a write-type command the block repeats two-byte transactions (05h plus one byte read in). It asserts done only after one of these reads returns status bit 0 clear. The other status bits have no effect.
- R9: req_op 7 (status read) is one transaction: 05h, then one byte returned on rd_data. No write enable is sent before it and no polling follows it.
- R10: Between two consecutive transactions, cs_n stays high for at least 2 system clock cycles.
- R11: The following requests produce a one-cycle err pulse, no done and no cs_n activity:
  - req_len of 0 with req_op 0, 1 or 2;
  - any req_op from 8 to 15.
- R12: Every transaction holds exactly 8 sck rising edges per byte. cs_n rises right after the last falling sck edge of the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken while req_ready is 1 |
| req_op | input | 4 | Operation: 0 read, 1 fast read, 2 program, 3/4/5 erase 4K/32K/64K, 6 chip erase, 7 status read |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Data byte count for reads and programs |
| req_ready | output | 1 | Block is idle and takes a request |
| wr_data | input | 8 | Program data byte |
| wr_ready | output | 1 | wr_data is taken in this cycle |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | rd_data holds a new byte |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is refused |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Some properties are checked by assertions on every cycle:
- the serial clock stays low while the select is high;
- mosi moves only on a falling clock edge;
- the select stays high for its minimum time after rising;
- wr_ready never appears outside a transaction;
- a refused request never coexists with bus activity or with done.

Other properties only the bench scenarios can show, because they depend on byte content and on the order of transactions:
- the opcode and address byte order;
- the dummy byte inserted for fast reads;
- the write enable placed before each write-type command;
- polling that stops only on a clear busy bit;
- the returned data values.

The bench uses a flash model that reports busy for a chosen number of polls.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 16,
  parameter int CS_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int DIV   = (CLK_DIV < 1) ? 1 : CLK_DIV;
  localparam int DIV_W = $clog2(DIV + 1);
  localparam int GAP   = (CS_GAP < 2) ? 2 : CS_GAP;
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  typedef enum logic [1:0] {K_WREN, K_MAIN, K_POLL} kind_t;

  st_t              st;
  kind_t            kind, nk;
  logic [2:0]       op;
  logic [23:0]      addr;
  logic [LEN_W-1:0] len;
  logic [DIV_W-1:0] div;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       sh;
  logic [6:0]       rx;
  logic             busy_r;
  logic [GAP_W-1:0] gap_cnt;

  function automatic logic [7:0] opcode(kind_t k, logic [2:0] o);
    if (k == K_WREN) return 8'h06;
    if (k == K_POLL) return 8'h05;
    case (o)
      3'd0: return 8'h03;
      3'd1: return 8'h0B;
      3'd2: return 8'h02;
      3'd3: return 8'h20;
      3'd4: return 8'h52;
      3'd5: return 8'hD8;
      3'd6: return 8'h60;
      default: return 8'h05;
    endcase
  endfunction

  logic is_rd, is_prog, is_wrt, req_bad, req_wrt;
  assign is_rd   = (op == 3'd0) || (op == 3'd1);
  assign is_prog = (op == 3'd2);
  assign is_wrt  = (op >= 3'd2) && (op <= 3'd6);
  assign req_bad = req_op[3] || ((req_op <= 4'd2) && (req_len == '0));
  assign req_wrt = (req_op >= 4'd2) && (req_op <= 4'd6);

  logic [2:0]       hdr;
  logic [CNT_W-1:0] data_n, last_idx, nidx;
  assign hdr = (kind != K_MAIN) ? 3'd1 :
               ((op == 3'd6) || (op == 3'd7)) ? 3'd1 :
               (op == 3'd1) ? 3'd5 : 3'd4;
  assign data_n = (kind == K_POLL) ? CNT_W'(1) :
                  (kind == K_WREN) ? CNT_W'(0) :
                  (is_rd || is_prog) ? CNT_W'(len) :
                  (op == 3'd7) ? CNT_W'(1) : CNT_W'(0);
  assign last_idx = CNT_W'(hdr) + data_n - CNT_W'(1);
  assign nidx     = byte_cnt + CNT_W'(1);

  logic tick, rise, fall, byte_end, last_byte, nxt_data, rd_take;
  assign tick      = (div == DIV_W'(DIV - 1));
  assign rise      = (st == S_XFER) && tick && !sck;
  assign fall      = (st == S_XFER) && tick && sck;
  assign byte_end  = fall && (bit_cnt == 3'd7);
  assign last_byte = (byte_cnt == last_idx);
  assign nxt_data  = (nidx >= CNT_W'(hdr));
  assign rd_take   = (kind == K_MAIN) && (is_rd || op == 3'd7) && (byte_cnt >= CNT_W'(hdr));

  assign wr_ready  = byte_end && !last_byte && (kind == K_MAIN) && is_prog && nxt_data;
  assign req_ready = (st == S_IDLE);
  assign mosi      = sh[7];

  logic [7:0] nb;
  assign nb = !nxt_data ? ((nidx == CNT_W'(1)) ? addr[23:16] :
                           (nidx == CNT_W'(2)) ? addr[15:8]  :
                           (nidx == CNT_W'(3)) ? addr[7:0]   : 8'h00)
                        : ((is_prog && kind == K_MAIN) ? wr_data : 8'h00);

  logic fin;
  always_comb begin
    fin = 1'b0;
    nk  = kind;
    case (kind)
      K_WREN:  nk = K_MAIN;
      K_MAIN:  if (is_wrt) nk = K_POLL; else fin = 1'b1;
      default: if (!busy_r) fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_MAIN; op <= '0; addr <= '0; len <= '0;
      div <= '0; bit_cnt <= '0; byte_cnt <= '0; sh <= '0; rx <= '0;
      busy_r <= 1'b0; gap_cnt <= '0; sck <= 1'b0; cs_n <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (req_bad) err <= 1'b1;
          else begin
            op <= req_op[2:0]; addr <= req_addr; len <= req_len;
            kind <= req_wrt ? K_WREN : K_MAIN;
            sh <= opcode(req_wrt ? K_WREN : K_MAIN, req_op[2:0]);
            st <= S_XFER; cs_n <= 1'b0;
            div <= '0; bit_cnt <= '0; byte_cnt <= '0;
          end
        end
        S_XFER: begin
          div <= tick ? '0 : div + DIV_W'(1);
          if (rise) begin
            sck <= 1'b1;
            rx  <= {rx[5:0], miso};
            if (bit_cnt == 3'd7) begin
              if (kind == K_POLL) busy_r <= miso;
              if (rd_take) begin rd_data <= {rx, miso}; rd_valid <= 1'b1; end
            end
          end
          if (fall) begin
            sck <= 1'b0;
            if (bit_cnt != 3'd7) begin
              sh <= {sh[6:0], 1'b0}; bit_cnt <= bit_cnt + 3'd1;
            end else if (last_byte) begin
              cs_n <= 1'b1; st <= S_GAP; gap_cnt <= '0;
            end else begin
              sh <= nb; bit_cnt <= '0; byte_cnt <= nidx;
            end
          end
        end
        S_GAP: if (gap_cnt == GAP_W'(GAP - 1)) begin
          if (fin) begin st <= S_IDLE; done <= 1'b1; end
          else begin
            kind <= nk; sh <= opcode(nk, op); st <= S_XFER; cs_n <= 1'b0;
            div <= '0; bit_cnt <= '0; byte_cnt <= '0;
          end
        end else gap_cnt <= gap_cnt + GAP_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_mosi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$fell(sck)) |-> $stable(mosi));
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  assert_wr_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !cs_n);
  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !done));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && req_ready));
endmodule

// File: tb/sim_spi_flash_seq.sv
module sim_spi_flash_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic req_ready, wr_ready, rd_valid, done, err, sck, cs_n, mosi;
  logic [7:0] wr_data = '0, rd_data;
  logic miso = 1'b0;

  always #5 clk = ~clk;

  spi_flash_seq u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [7:0] txb [0:511];
  int txn [0:15];
  int txf [0:15];
  logic [7:0] pbuf [0:15];
  logic [7:0] rbuf [0:15];
  int ntx = 0, rcnt = 0, widx = 0, ndone = 0, nerr = 0;
  int gapbad = 0, mosibad = 0, hcnt = 0, bc = 0, busy_left = 0;
  logic [7:0] stat_idle = 8'h00, cur = '0;
  bit wpend = 0, pcs = 1, psck = 0, pmosi = 0;

  function automatic logic [7:0] dpat(int k);
    return 8'(8'h5A + k * 37);
  endfunction

  function automatic logic sbit(int n);
    int bi;
    logic [7:0] v, op0;
    bi = n / 8;
    op0 = txb[ntx * 32];
    v = 8'h00;
    if (bi >= 1) begin
      if (op0 == 8'h05) v = (busy_left > 0) ? 8'h03 : stat_idle;
      else if (op0 == 8'h03 && bi >= 4) v = dpat(bi - 4);
      else if (op0 == 8'h0B && bi >= 5) v = dpat(bi - 5);
    end
    return v[7 - (n % 8)];
  endfunction

  initial forever begin
    @(negedge clk);
    if (wpend) begin widx++; wr_data = pbuf[widx % 16]; wpend = 0; end
    if (wr_ready) wpend = 1;
    if (rd_valid) begin rbuf[rcnt % 16] = rd_data; rcnt++; end
    if (done) ndone++;
    if (err) nerr++;
    if (!cs_n && pcs) begin
      if (ntx > 0 && hcnt < 2) gapbad++;
      bc = 0; miso = sbit(0);
    end
    if (cs_n && !pcs && ntx < 16) begin
      txn[ntx] = bc / 8; txf[ntx] = bc % 8;
      if (txb[ntx * 32] == 8'h05 && busy_left > 0) busy_left--;
      ntx++; hcnt = 0;
    end
    if (cs_n) hcnt++;
    if (!cs_n && !pcs) begin
      if (sck && !psck) begin
        cur = {cur[6:0], mosi}; bc++;
        if (bc % 8 == 0 && bc <= 256 && ntx < 16) txb[ntx * 32 + bc / 8 - 1] = cur;
        miso = sbit(bc);
      end
      if (mosi !== pmosi && !(psck && !sck)) mosibad++;
    end
    pcs = cs_n; psck = sck; pmosi = mosi;
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    ntx = 0; rcnt = 0; widx = 0; wpend = 0; ndone = 0; nerr = 0;
    gapbad = 0; mosibad = 0; wr_data = pbuf[0];
    for (int i = 0; i < 512; i++) txb[i] = 8'h00;
  endtask

  task automatic run_req(input logic [3:0] o, input logic [23:0] a, input logic [15:0] l);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_op = o; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (ndone == 0 && nerr == 0 && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk("timeout", 1, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sck", int'(sck), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 done/err/rd_valid", int'({done, err, rd_valid}), 0);
  endtask

  task automatic t_read();
    clear_log();
    run_req(4'd0, 24'h123456, 16'd4);
    chk("R3 tx count", ntx, 1);
    chk("R12 bytes", txn[0], 8);
    chk("R12 whole bytes", txf[0], 0);
    chk("R3 opcode", int'(txb[0]), 8'h03);
    chk("R3 addr hi", int'(txb[1]), 8'h12);
    chk("R3 addr mid", int'(txb[2]), 8'h34);
    chk("R3 addr lo", int'(txb[3]), 8'h56);
    chk("R3 rd count", rcnt, 4);
    for (int k = 0; k < 4; k++) chk("R3 data", int'(rbuf[k]), int'(dpat(k)));
    chk("R2 mosi edges", mosibad, 0);
    chk("R3 done", ndone, 1);
  endtask

  task automatic t_fast();
    clear_log();
    run_req(4'd1, 24'hABCDEF, 16'd3);
    chk("R4 tx count", ntx, 1);
    chk("R4 bytes", txn[0], 8);
    chk("R4 opcode", int'(txb[0]), 8'h0B);
    chk("R4 addr", int'({txb[1], txb[2], txb[3]}), 24'hABCDEF);
    chk("R4 dummy", int'(txb[4]), 8'h00);
    chk("R4 rd count", rcnt, 3);
    for (int k = 0; k < 3; k++) chk("R4 data", int'(rbuf[k]), int'(dpat(k)));
    chk("R2 mosi edges", mosibad, 0);
  endtask

  task automatic t_program();
    for (int i = 0; i < 16; i++) pbuf[i] = 8'(8'hC3 ^ (i * 29));
    clear_log();
    busy_left = 2; stat_idle = 8'h00;
    run_req(4'd2, 24'h000100, 16'd5);
    chk("R5 tx count", ntx, 5);
    chk("R5 wren len", txn[0], 1);
    chk("R5 wren code", int'(txb[0]), 8'h06);
    chk("R7 cmd len", txn[1], 9);
    chk("R7 opcode", int'(txb[32]), 8'h02);
    chk("R7 addr", int'({txb[33], txb[34], txb[35]}), 24'h000100);
    for (int k = 0; k < 5; k++) chk("R7 data", int'(txb[36 + k]), int'(pbuf[k]));
    for (int p = 2; p < 5; p++) begin
      chk("R8 poll code", int'(txb[p * 32]), 8'h05);
      chk("R8 poll len", txn[p], 2);
    end
    chk("R8 done once", ndone, 1);
    chk("R10 cs gap", gapbad, 0);
    chk("R2 mosi edges", mosibad, 0);
  endtask

  task automatic t_erase();
    logic [7:0] codes [0:2];
    codes[0] = 8'h20; codes[1] = 8'h52; codes[2] = 8'hD8;
    for (int e = 0; e < 3; e++) begin
      clear_log();
      busy_left = 0; stat_idle = 8'hFE;
      run_req(4'(3 + e), 24'h0F1000 + 24'(e * 24'h010000), 16'd0);
      chk("R5 wren", int'(txb[0]), 8'h06);
      chk("R6 opcode", int'(txb[32]), int'(codes[e]));
      chk("R6 addr", int'({txb[33], txb[34], txb[35]}), int'(24'h0F1000 + 24'(e * 24'h010000)));
      chk("R6 cmd len", txn[1], 4);
      chk("R8 bit0 only", ntx, 3);
      chk("R8 done", ndone, 1);
    end
  endtask

  task automatic t_chip();
    clear_log();
    busy_left = 1; stat_idle = 8'h00;
    run_req(4'd6, 24'h555555, 16'd0);
    chk("R6 chip tx count", ntx, 4);
    chk("R5 chip wren", int'(txb[0]), 8'h06);
    chk("R6 chip opcode", int'(txb[32]), 8'h60);
    chk("R6 chip no addr", txn[1], 1);
    chk("R8 chip polls", int'(txb[96]), 8'h05);
    chk("R10 cs gap", gapbad, 0);
  endtask

  task automatic t_status();
    clear_log();
    busy_left = 0; stat_idle = 8'h5C;
    run_req(4'd7, 24'h000000, 16'd9);
    chk("R9 tx count", ntx, 1);
    chk("R9 opcode", int'(txb[0]), 8'h05);
    chk("R9 len", txn[0], 2);
    chk("R9 rd count", rcnt, 1);
    chk("R9 value", int'(rbuf[0]), 8'h5C);
    chk("R9 done", ndone, 1);
  endtask

  task automatic t_reject();
    clear_log();
    run_req(4'd0, 24'h000010, 16'd0);
    run_req(4'd2, 24'h000010, 16'd0);
    run_req(4'd9, 24'h000010, 16'd3);
    chk("R11 err count", nerr, 3);
    chk("R11 no bus", ntx, 0);
    chk("R11 no done", ndone, 0);
    chk("R11 cs idle", int'(cs_n), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) pbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read();
    t_fast();
    t_program();
    t_erase();
    t_chip();
    t_status();
    t_reject();
    finish_run();
  end
endmodule